// File: doc/BRIEF.md
# Bit-Serial CRC-16 Engine

This block computes a 16-bit cyclic redundancy code one bit per clock for the generator polynomial x^16 + x^15 + x^2 + 1. Each bit accepted under a valid strobe is folded into a 16-bit remainder register through XOR feedback taps. The register holds whenever the strobe is low. It is loaded with all ones by reset, or by a synchronous start pulse at the head of every message.

A transmitter shifts its message through the block and then appends the 16-bit register value, most significant bit first. A receiver shifts the whole message and code through a second instance. After the last code bit the remainder is zero and a registered match flag is high. Any single-bit error, any two-bit error, or any burst shorter than 16 bits leaves a non-zero remainder, and the flag stays low.

Top module: `crc16_serial`

## Requirements
- R1: While `rst` is high at a clock edge, the register is loaded with 16'hFFFF and `match` is 0. Both values are visible one cycle after that edge.
- R2: When `start` is high at a clock edge, the register becomes 16'hFFFF after that edge. This happens whatever the values of `bit_valid` and `bit_in`, so the start pulse wins over a shift in the same cycle.
- R3: When `start` is low and `bit_valid` is low at an edge, `crc` keeps its value across that edge.
- R4: When `start` is low and `bit_valid` is high, let f = crc[15] XOR `bit_in`. The new value is then crc[0]=f, crc[2]=crc[1] XOR f, crc[15]=crc[14] XOR f, and crc[i]=crc[i-1] for every other bit. The new value appears on `crc` one cycle after the accepted bit, with crc[15] as the most significant bit.
- R5: Start from 16'hFFFF, shift a message, then shift the resulting `crc` value most significant bit first. The register then reads 16'h0000.
- R6: `match` is 1 in exactly the cycles where `crc` equals 16'h0000, and it changes in the same cycle as `crc`.
- R7: Inverting any one bit of a message changes the final `crc` value.
- R8: Inverting two bits of a message changes the final `crc` value. So does any error burst shorter than 16 bits, meaning its first and last bits are inverted and the bits between are arbitrary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, presets the register |
| start | input | 1 | Synchronous preset at the head of a message |
| bit_valid | input | 1 | Qualifies `bit_in` for this clock |
| bit_in | input | 1 | Serial data bit |
| crc | output | 16 | Running remainder, crc[15] is the MSB |
| match | output | 1 | High when the remainder equals the zero residue |

## Verification
The assertions take `start`, `bit_valid` and `bit_in` to be known, non-X levels at every clock after reset. They also take `rst` to be released only once the register has seen a full reset edge. The tap and hold properties then compare each new register value with the previous one.

The stimulus drives every input only on the falling edge, from tasks, and starts each message with a start pulse. It inserts random idle cycles with `bit_valid` low between accepted bits, and it includes one cycle where start and a valid bit coincide, so the priority rule is exercised without ever leaving inputs undefined.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W = 16;
  // x^16 + x^15 + x^2 + 1, the x^16 term implied by the shift out of the MSB
  localparam logic [CRC_W-1:0] CRC_POLY    = 16'h8005;
  localparam logic [CRC_W-1:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE = 16'h0000;
endpackage

// File: rtl/crc16_step.sv
// One Galois LFSR step: combinational next value for an accepted bit.
module crc16_step #(
  parameter int unsigned             W    = crc16_pkg::CRC_W,
  parameter logic [W-1:0]            POLY = crc16_pkg::CRC_POLY
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb = cur[W-1] ^ din;

  assign nxt[0] = POLY[0] ? fb : 1'b0;

  genvar gi;
  generate
    for (gi = 1; gi < W; gi++) begin : g_tap
      if (POLY[gi]) begin : g_xor
        assign nxt[gi] = cur[gi-1] ^ fb;
      end else begin : g_pass
        assign nxt[gi] = cur[gi-1];
      end
    end
  endgenerate
endmodule

// File: rtl/crc16_state.sv
// Remainder register with preset priority and hold.
module crc16_state #(
  parameter int unsigned  W      = crc16_pkg::CRC_W,
  parameter logic [W-1:0] POLY   = crc16_pkg::CRC_POLY,
  parameter logic [W-1:0] PRESET = crc16_pkg::CRC_PRESET
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         valid,
  input  logic         din,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_d
);
  logic [W-1:0] shifted;

  crc16_step #(.W(W), .POLY(POLY)) step_i (
    .cur (state_q),
    .din (din),
    .nxt (shifted)
  );

  always_comb begin
    if (start)      state_d = PRESET;
    else if (valid) state_d = shifted;
    else            state_d = state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PRESET;
    else     state_q <= state_d;
  end

  assert_preset_priority_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (state_q == PRESET));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!start && !valid) |=> $stable(state_q));

  assert_feedback_lsb_R4: assert property (@(posedge clk) disable iff (rst)
    (!start && valid) |=> (state_q[0] == ($past(state_q[W-1]) ^ $past(din))));

  assert_shift_msb_R4: assert property (@(posedge clk) disable iff (rst)
    (!start && valid) |=> (state_q[W-1] == ($past(state_q[W-2]) ^ $past(state_q[W-1]) ^ $past(din))));
endmodule

// File: rtl/crc16_match.sv
// Registered residue compare, computed from the next state so it lines up with the register.
module crc16_match #(
  parameter int unsigned  W       = crc16_pkg::CRC_W,
  parameter logic [W-1:0] PRESET  = crc16_pkg::CRC_PRESET,
  parameter logic [W-1:0] RESIDUE = crc16_pkg::CRC_RESIDUE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] next_val,
  input  logic [W-1:0] cur_val,
  output logic         hit_q
);
  localparam logic RESET_HIT = (PRESET == RESIDUE);

  always_ff @(posedge clk) begin
    if (rst) hit_q <= RESET_HIT;
    else     hit_q <= (next_val == RESIDUE);
  end

  assert_match_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    hit_q == (cur_val == RESIDUE));
endmodule

// File: rtl/crc16_serial.sv
module crc16_serial #(
  parameter int unsigned                       W       = crc16_pkg::CRC_W,
  parameter logic [W-1:0]                      POLY    = crc16_pkg::CRC_POLY,
  parameter logic [W-1:0]                      PRESET  = crc16_pkg::CRC_PRESET,
  parameter logic [W-1:0]                      RESIDUE = crc16_pkg::CRC_RESIDUE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         bit_valid,
  input  logic         bit_in,
  output logic [W-1:0] crc,
  output logic         match
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  crc16_state #(.W(W), .POLY(POLY), .PRESET(PRESET)) state_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .valid   (bit_valid),
    .din     (bit_in),
    .state_q (st_q),
    .state_d (st_d)
  );

  crc16_match #(.W(W), .PRESET(PRESET), .RESIDUE(RESIDUE)) match_i (
    .clk      (clk),
    .rst      (rst),
    .next_val (st_d),
    .cur_val  (st_q),
    .hit_q    (match)
  );

  assign crc = st_q;

  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> (crc == PRESET));
endmodule

// File: tb/crc16_serial_tb_top.sv
`timescale 1ns/1ps
module crc16_serial_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic [15:0] crc;
  logic        match;

  int checks = 0;
  int errors = 0;
  bit [15:0] model = 16'hFFFF;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  crc16_serial dut_i (
    .clk(clk), .rst(rst), .start(start),
    .bit_valid(bit_valid), .bit_in(bit_in),
    .crc(crc), .match(match)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural polynomial division step on an integer
  function automatic bit [15:0] ref_step(bit [15:0] m, bit d);
    int v;
    v = int'(m) * 2;
    if (((m >> 15) & 16'd1) != 16'(d)) v = v ^ 32'h18005;
    return v[15:0];
  endfunction

  // one clock: drive on falling edge, model at rising, compare just after
  task automatic cyc(input bit s, input bit v, input bit d, input string req);
    @(negedge clk);
    start = s; bit_valid = v; bit_in = d;
    @(posedge clk);
    if (s) model = 16'hFFFF;
    else if (v) model = ref_step(model, d);
    #1;
    check(crc == model, req, crc, model);
    check(match == (model == 16'h0000), "R6", {15'd0, match}, {15'd0, model == 16'h0000});
  endtask

  task automatic run_msg(input bit [63:0] msg, input int len, input bit gaps, output bit [15:0] res);
    cyc(1'b1, 1'b0, 1'b0, "R2");
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) cyc(1'b0, 1'b0, $urandom_range(0, 1) != 0, "R3");
      cyc(1'b0, 1'b1, msg[i], "R4");
    end
    res = crc;
  endtask

  initial begin
    bit [15:0] base, got, code;
    bit [63:0] m, e;
    int len;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(crc == 16'hFFFF, "R1", crc, 16'hFFFF);
    check(match == 1'b0, "R1", {15'd0, match}, 16'd0);

    // random messages with idle gaps, then append the code MSB first
    for (int n = 0; n < 20; n++) begin
      m = {$urandom, $urandom};
      len = $urandom_range(8, 64);
      run_msg(m, len, 1'b1, code);
      for (int k = 15; k >= 0; k--) cyc(1'b0, 1'b1, code[k], "R5");
      check(crc == 16'h0000, "R5", crc, 16'h0000);
      check(match == 1'b1, "R6", {15'd0, match}, 16'd1);
    end

    // start coincident with a valid bit
    cyc(1'b0, 1'b1, 1'b1, "R4");
    cyc(1'b1, 1'b1, 1'b1, "R2");
    check(crc == 16'hFFFF, "R2", crc, 16'hFFFF);

    // long idle hold
    cyc(1'b0, 1'b1, 1'b0, "R4");
    got = crc;
    repeat (5) cyc(1'b0, 1'b0, 1'b1, "R3");
    check(crc == got, "R3", crc, got);

    // single-bit errors
    m = 64'hC3A5_1F00_9E27_5B6D;
    run_msg(m, 48, 1'b0, base);
    for (int i = 0; i < 48; i++) begin
      e = m; e[i] = ~e[i];
      run_msg(e, 48, 1'b0, got);
      check(got != base, "R7", got, base);
    end

    // double-bit errors
    for (int n = 0; n < 12; n++) begin
      int a, b;
      a = $urandom_range(0, 47);
      b = $urandom_range(0, 47);
      if (a == b) b = (a + 7) % 48;
      e = m; e[a] = ~e[a]; e[b] = ~e[b];
      run_msg(e, 48, 1'b0, got);
      check(got != base, "R8", got, base);
    end

    // bursts of length 2..15
    for (int bl = 2; bl <= 15; bl++) begin
      int p;
      bit [63:0] pat;
      p = $urandom_range(0, 48 - bl);
      pat = 64'({$urandom} & ((32'd1 << bl) - 1)) | 64'd1 | (64'd1 << (bl - 1));
      e = m ^ (pat << p);
      run_msg(e, 48, 1'b0, got);
      check(got != base, "R8", got, base);
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule